// File: doc/BRIEF.md
# Shared Transmit/Receive Descriptor Ring Manager

This block owns a table of 128 buffer descriptors that a transmit ring and a receive ring share. Every descriptor takes two 32-bit words: a flags word (length in the upper half, control and status bits in the lower half) and a buffer pointer. A programmable split value divides the table: entries below the split belong to the transmit ring, entries from the split up to the last one belong to the receive ring.

The host reads and writes the table as 32-bit words over a byte address. The block tracks the current transmit and receive entries and tells the engines when the current transmit descriptor may be sent (`tx_go`) and when the current receive descriptor may take a frame (`rx_ok`). The engines move the data and return a one-cycle done pulse. The block then writes the completion status back into the descriptor, hands ownership back to the host, moves the index on with its wrap rules, and pulses an event output when the descriptor asked for one. Both go signals are evaluated from the table contents every cycle, so any host write to the table or any enable change is taken into account immediately.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset the split is 0x40, the transmit index is 0, the receive index is 0x40, every table word reads 0, and `tx_go`, `rx_ok`, `tx_evt` and `rx_evt` are low.
- R2: Entry i has its flags word at byte address 8*i and its pointer word at 8*i+4. A host write with `host_we` stores the word, and `host_rdata` returns it combinationally. `tx_ptr` and `rx_ptr` show the pointer word of the current entries. Host addresses are word aligned.
- R3: `tx_go` is high only when all of these hold: `tx_enable` has been high for at least one clock edge, the split is nonzero, bit 15 (ready) of the current transmit flags is set, and the length field in bits 31:16 is greater than 4. `tx_len` shows that length field.
- R4: When transmit completes, the transmit index becomes 0 if bit 13 (wrap) of the descriptor is set. Otherwise it becomes index+1, or 0 if index+1 is at or above the split.
- R5: When transmit completes, bits 15 and 8:0 of the flags word are cleared and all other bits keep their value. The pointer word is not changed. One cycle later `tx_evt` pulses if bit 14 of the descriptor was set.
- R6: `rx_ok` is high only when all of these hold: `rx_enable` has been high for at least one clock edge, the split is below 0x80, and bit 15 (empty) of the current receive flags is set.
- R7: When receive completes, the receive index is reloaded with the split if bit 13 (wrap) of the descriptor is set or if the index is 0x7F. Otherwise it increments.
- R8: When receive completes, bits 31:16 take `rx_len`, bits 15 and 8:0 are cleared, bit 7 takes `rx_miss`, bit 3 takes `rx_toolong`, and bits 14:9 are kept. One cycle later `rx_evt` pulses if bit 14 was set.
- R9: A rising edge of `tx_enable` sets the transmit index to 0. A rising edge of `rx_enable` loads the receive index with the split.
- R10: A done pulse while the matching go/ok signal is low is ignored: the index does not move and no event is raised. If a host write hits the word that a completion updates in the same cycle, the completion's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host table write strobe |
| host_addr | input | 10 | Host byte address into the table |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Table word at host_addr |
| split_we | input | 1 | Load the ring split value |
| split_wdata | input | 8 | New split value |
| ring_split | output | 8 | Current split value |
| tx_enable | input | 1 | Transmit ring enable |
| rx_enable | input | 1 | Receive ring enable |
| tx_go | output | 1 | Current transmit descriptor may be sent |
| tx_len | output | 16 | Length field of the current transmit descriptor |
| tx_ptr | output | 32 | Buffer pointer of the current transmit descriptor |
| tx_idx | output | 7 | Current transmit index |
| tx_done | input | 1 | Transmit engine finished the current descriptor |
| tx_evt | output | 1 | Transmit event pulse |
| rx_ok | output | 1 | Current receive descriptor may take a frame |
| rx_ptr | output | 32 | Buffer pointer of the current receive descriptor |
| rx_idx | output | 7 | Current receive index |
| rx_done | input | 1 | Receive engine finished a frame |
| rx_len | input | 16 | Length of the received frame |
| rx_miss | input | 1 | Address-miss status for the frame |
| rx_toolong | input | 1 | Too-long status for the frame |
| rx_evt | output | 1 | Receive event pulse |

## Verification
Transmit readiness is swept over lengths 0 to 8 with the ready bit set and cleared, with the enable off, and with a zero split. This separates the strict "greater than 4" boundary from the other gating terms. The transmit ring is run with split 3 through seven completions, with the wrap and event bits varied. This tells apart wrap-by-bit, wrap-at-split and plain increment, and the flags read back after each completion show exactly which bits are cleared. The receive ring runs with split 0x7C so that it crosses entry 0x7F, takes a wrap bit, and sees every combination of miss and too-long. Separate patterns cover same-cycle host collisions, done pulses that must be ignored, and enable edges that must reload the indices.

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl #(
  parameter int ENTRIES = 128,
  parameter int SPLIT_RST = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [$clog2(2*ENTRIES)+1:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        split_we,
  input  logic [$clog2(ENTRIES):0] split_wdata,
  output logic [$clog2(ENTRIES):0] ring_split,
  input  logic        tx_enable,
  input  logic        rx_enable,
  output logic        tx_go,
  output logic [15:0] tx_len,
  output logic [31:0] tx_ptr,
  output logic [$clog2(ENTRIES)-1:0] tx_idx,
  input  logic        tx_done,
  output logic        tx_evt,
  output logic        rx_ok,
  output logic [31:0] rx_ptr,
  output logic [$clog2(ENTRIES)-1:0] rx_idx,
  input  logic        rx_done,
  input  logic [15:0] rx_len,
  input  logic        rx_miss,
  input  logic        rx_toolong,
  output logic        rx_evt
);
  localparam int IW    = $clog2(ENTRIES);
  localparam int SW    = IW + 1;
  localparam int WORDS = 2 * ENTRIES;
  localparam int WW    = $clog2(WORDS);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);
  localparam logic [15:0] CLR_LO = 16'h81FF;

  logic [31:0]   tbl [WORDS];
  logic [SW-1:0] split_q;
  logic [IW-1:0] tx_q, rx_q;
  logic          tx_en_q, rx_en_q;

  wire [WW-1:0] hw    = host_addr[WW+1:2];
  wire [WW-1:0] tx_fw = {tx_q, 1'b0};
  wire [WW-1:0] rx_fw = {rx_q, 1'b0};
  wire [31:0]   tx_fl = tbl[tx_fw];
  wire [15:0]   rx_lo = tbl[rx_fw][15:0];

  assign tx_go = tx_enable && tx_en_q && (split_q != '0) && tx_fl[15] && (tx_fl[31:16] > 16'd4);
  assign rx_ok = rx_enable && rx_en_q && (split_q < SW'(ENTRIES)) && rx_lo[15];

  wire tx_fire = tx_done && tx_go;
  wire rx_fire = rx_done && rx_ok;

  wire [SW-1:0] tx_inc  = {1'b0, tx_q} + 1'b1;
  wire [IW-1:0] tx_next = (tx_fl[13] || tx_inc >= split_q) ? '0 : tx_inc[IW-1:0];
  wire [IW-1:0] rx_next = (rx_lo[13] || rx_q == LAST) ? split_q[IW-1:0] : rx_q + 1'b1;

  wire host_blk = (tx_fire && hw == tx_fw) || (rx_fire && hw == rx_fw);

  wire [15:0] rx_new_lo = (rx_lo & ~CLR_LO) | {8'd0, rx_miss, 3'd0, rx_toolong, 3'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
    end else begin
      if (host_we && !host_blk) tbl[hw] <= host_wdata;
      if (tx_fire) tbl[tx_fw] <= tx_fl & ~{16'd0, CLR_LO};
      if (rx_fire) tbl[rx_fw] <= {rx_len, rx_new_lo};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q <= SW'(SPLIT_RST);
      tx_q    <= '0;
      rx_q    <= IW'(SPLIT_RST);
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      tx_evt  <= 1'b0;
      rx_evt  <= 1'b0;
    end else begin
      if (split_we) split_q <= split_wdata;
      tx_en_q <= tx_enable;
      rx_en_q <= rx_enable;
      tx_evt  <= tx_fire && tx_fl[14];
      rx_evt  <= rx_fire && rx_lo[14];
      if (tx_enable && !tx_en_q) tx_q <= '0;
      else if (tx_fire)          tx_q <= tx_next;
      if (rx_enable && !rx_en_q) rx_q <= split_q[IW-1:0];
      else if (rx_fire)          rx_q <= rx_next;
    end
  end

  assign host_rdata = tbl[hw];
  assign ring_split = split_q;
  assign tx_len     = tx_fl[31:16];
  assign tx_ptr     = tbl[{tx_q, 1'b1}];
  assign rx_ptr     = tbl[{rx_q, 1'b1}];
  assign tx_idx     = tx_q;
  assign rx_idx     = rx_q;

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> host_addr[1:0] == 2'b00);
  assert_tx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_go) |=> (tx_idx == '0 || tx_idx == $past(tx_idx) + 1'b1));
  assert_rx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ok) |=> (rx_idx == $past(ring_split[IW-1:0]) || rx_idx == $past(rx_idx) + 1'b1));
  assert_tx_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |-> $past(tx_done && tx_go));
  assert_rx_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> $past(rx_done && rx_ok));
  assert_tx_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_enable) |=> tx_idx == '0);
  assert_rx_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_enable) |=> rx_idx == $past(ring_split[IW-1:0]));
  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_go && !tx_enable) |=> $stable(tx_idx));
endmodule

// File: tb/desc_ring_ctl_tb.sv
module desc_ring_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic host_we = 0; logic [9:0] host_addr = 0; logic [31:0] host_wdata = 0, host_rdata;
  logic split_we = 0; logic [7:0] split_wdata = 0, ring_split;
  logic tx_enable = 0, rx_enable = 0, tx_go, rx_ok, tx_done = 0, rx_done = 0, tx_evt, rx_evt;
  logic [15:0] tx_len, rx_len = 0; logic [31:0] tx_ptr, rx_ptr;
  logic [6:0] tx_idx, rx_idx; logic rx_miss = 0, rx_toolong = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  desc_ring_ctl dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic hwrite(input int a, input logic [31:0] d);
    host_we = 1; host_addr = 10'(a); host_wdata = d; tick(); host_we = 0;
  endtask
  task automatic hread(input int a, output logic [31:0] d);
    host_addr = 10'(a); #0.5; d = host_rdata;
  endtask
  task automatic set_split(input int v);
    split_we = 1; split_wdata = 8'(v); tick(); split_we = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int e, nx, bad;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk(ring_split, 32'h40, "R1 split");
    chk(tx_idx, 0, "R1 tx_idx");
    chk(rx_idx, 32'h40, "R1 rx_idx");
    chk({tx_go, rx_ok, tx_evt, rx_evt}, 0, "R1 go/ok/evt");
    bad = 0;
    for (int w = 0; w < 256; w++) begin hread(w*4, d); if (d != 0) bad++; end
    chk(bad, 0, "R1 table zero");

    // R2 full table write/read sweep
    for (int w = 0; w < 256; w++) hwrite(w*4, 32'hA5000000 ^ 32'(w * 32'h10101));
    bad = 0;
    for (int w = 0; w < 256; w++) begin hread(w*4, d); if (d != (32'hA5000000 ^ 32'(w * 32'h10101))) bad++; end
    chk(bad, 0, "R2 readback");
    chk(tx_ptr, 32'hA5000000 ^ 32'h10101, "R2 tx_ptr");
    chk(rx_ptr, 32'hA5000000 ^ 32'(129 * 32'h10101), "R2 rx_ptr");
    for (int w = 0; w < 256; w++) hwrite(w*4, 0);

    // R3 length sweep and gating
    hwrite(0, {16'd9, 16'h8000});
    chk(tx_go, 0, "R3 disabled");
    tx_enable = 1; tick();
    for (int l = 0; l <= 8; l++) begin
      hwrite(0, {16'(l), 16'h8000});
      chk(tx_go, (l > 4) ? 1 : 0, "R3 length gate");
      chk(tx_len, l, "R3 tx_len");
      hwrite(0, {16'(l), 16'h0000});
      chk(tx_go, 0, "R3 ready clear");
    end
    hwrite(0, {16'd60, 16'h8000});
    set_split(0);
    chk(tx_go, 0, "R3 split zero");
    set_split(3);
    chk(tx_go, 1, "R3 split nonzero");
    hwrite(0, 0);

    // R4/R5 transmit ring with split 3
    e = 0;
    for (int k = 0; k < 7; k++) begin
      logic wr, irq;
      wr = (k == 4); irq = k[0];
      hwrite(e*8 + 4, 32'hB0000000 + 32'(k));
      hwrite(e*8, {16'd60, 16'h99FF | (irq ? 16'h4000 : 16'h0) | (wr ? 16'h2000 : 16'h0)});
      chk(tx_go, 1, "R3 ready entry");
      tx_done = 1; tick(); tx_done = 0;
      nx = wr ? 0 : ((e + 1 >= 3) ? 0 : e + 1);
      chk(tx_evt, irq, "R5 tx_evt");
      chk(tx_idx, nx, "R4 tx index");
      hread(e*8, d);
      chk(d, {16'd60, 16'h1800 | (irq ? 16'h4000 : 16'h0) | (wr ? 16'h2000 : 16'h0)}, "R5 flags");
      hread(e*8 + 4, d);
      chk(d, 32'hB0000000 + 32'(k), "R5 ptr kept");
      e = nx;
    end
    tick();
    chk(tx_evt, 0, "R5 evt one cycle");

    // R10 collision and ignored done
    hwrite(e*8, {16'd60, 16'h8000});
    host_we = 1; host_addr = 10'(e*8); host_wdata = 32'hFFFFFFFF; tx_done = 1;
    tick(); host_we = 0; tx_done = 0;
    hread(e*8, d);
    chk(d, {16'd60, 16'h0000}, "R10 engine wins");
    nx = (e + 1 >= 3) ? 0 : e + 1;
    chk(tx_idx, nx, "R10 tx advanced");
    e = nx;
    tx_done = 1; tick(); tx_done = 0;
    chk(tx_idx, e, "R10 tx done ignored");
    chk(tx_evt, 0, "R10 no tx_evt");

    // R9 transmit enable edge
    tx_enable = 0; tick();
    hwrite(0, {16'd60, 16'h8000});
    tx_enable = 1; #0.5;
    chk(tx_go, 0, "R9 go waits a cycle");
    #0.5; tick();
    chk(tx_idx, 0, "R9 tx reload");
    chk(tx_go, 1, "R9 go after edge");
    tx_enable = 0; tick();

    // R6/R7/R8 receive ring with split 0x7C
    set_split(32'h7C);
    chk(rx_ok, 0, "R6 disabled");
    rx_enable = 1; tick();
    chk(rx_idx, 32'h7C, "R9 rx reload");
    e = 32'h7C;
    for (int k = 0; k < 6; k++) begin
      logic wr, irq;
      wr = (k == 4); irq = k[0];
      hwrite(e*8, {16'hABCD, 16'h81FF | (irq ? 16'h4000 : 16'h0) | (wr ? 16'h2000 : 16'h0)});
      chk(rx_ok, 1, "R6 empty entry");
      rx_len = 16'(100 + k); rx_miss = k[0]; rx_toolong = k[1];
      rx_done = 1; tick(); rx_done = 0;
      nx = (wr || e == 127) ? 32'h7C : e + 1;
      chk(rx_evt, irq, "R8 rx_evt");
      chk(rx_idx, nx, "R7 rx index");
      hread(e*8, d);
      chk(d, {16'(100 + k), (irq ? 16'h4000 : 16'h0) | (wr ? 16'h2000 : 16'h0)
                | (k[0] ? 16'h0080 : 16'h0) | (k[1] ? 16'h0008 : 16'h0)}, "R8 flags");
      e = nx;
    end
    hwrite(e*8, 0);
    chk(rx_ok, 0, "R6 not empty");
    rx_done = 1; tick(); rx_done = 0;
    chk(rx_idx, e, "R10 rx done ignored");
    chk(rx_evt, 0, "R10 no rx_evt");
    hwrite(e*8, {16'd0, 16'h8000});
    chk(rx_ok, 1, "R6 empty again");
    set_split(32'h80);
    chk(rx_ok, 0, "R6 split at 0x80");
    chk(rx_idx, e, "R9 no reload without edge");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule